// File: doc/BRIEF.md
# SPI master serial-clock and select timing generator

This block drives the serial clock and sets the timing around each transfer of an SPI master. A start strobe arrives with a set of per-command fields. The block asserts a chip-select enable and waits out a lead interval. It then runs the serial clock for the requested number of bits, with the clock period set by a baud code. After the last clock edge it drops the select and waits out a trailing deselect interval, which gives a slow peripheral such as a serial converter time to finish. The shift register, the command storage and the queue that feeds it all sit outside this block. They act on the one-cycle shift and sample strobes it produces.

The clock runs at the system clock divided by twice the baud code. The lead interval is either half a serial-clock period or a programmed count. The trailing interval is either a fixed standard length or a programmed multiple of 32 clocks. Every field is captured when a start is accepted, so the upstream logic may load the next command while the current transfer runs. The code that feeds the baud field comes out of reset at 4, which gives a serial clock of one eighth of the system clock.

Top module: `spi_sck_timer`

## Requirements
- R1: While the baud code is 0 or 1 the divider is off: a start is ignored, busy stays low and sck stays at the idle level set by cpol.
- R2: During a transfer each half period of sck lasts exactly baud_code system clocks, so one full period is 2 x baud_code clocks (code 2 divides by 4, code 255 by 510).
- R3: With lead_sel = 0 the first sck transition comes baud_code clocks after the first cycle in which cs_act is high, which is half of one sck period.
- R4: With lead_sel = 1 the first sck transition comes lead_code clocks after cs_act rises, except that lead_code 0 gives 128 clocks and lead_code 1 gives 2 clocks.
- R5: A transfer of xfer_len bits makes 2 x xfer_len sck transitions, and xfer_len 0 stands for 16 bits. After the last transition sck rests at its idle level for one more half period before cs_act drops.
- R6: cpol sets the idle level of sck. Transitions are numbered from 1, and the odd ones are the leading edges. With cpha = 0, sample_stb pulses on odd edges and shift_stb pulses on even edges other than the last one. With cpha = 1, shift_stb pulses on odd edges and sample_stb on even edges. Each strobe is one cycle long and appears in the first cycle in which sck shows its new level.
- R7: After cs_act drops, busy stays high with sck idle for the trailing interval. That interval is 17 clocks with post_sel = 0, and 32 x post_code clocks with post_sel = 1, where post_code 0 counts as 256.
- R8: busy rises in the cycle after an accepted start and falls at the end of the trailing interval. In the cycle busy falls, done is high for exactly one cycle. A start while busy is high is ignored, and a start in the done cycle is accepted.
- R9: cs_act is high from the cycle after an accepted start until the end of the rest half period that follows the last sck transition, and is never high while busy is low.
- R10: The fields are captured when a start is accepted. Changes to baud_code, lead_sel, lead_code, post_sel, post_code, xfer_len or cpha during a transfer have no effect on it.
- R11: Synchronous reset leaves busy, cs_act, done and both strobes low, and sck at the cpol level.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| start | input | 1 | Request to begin a transfer |
| lead_sel | input | 1 | 0: half-period lead interval, 1: programmed lead interval |
| post_sel | input | 1 | 0: standard trailing interval, 1: programmed trailing interval |
| baud_code | input | 8 | Half period of sck in system clocks; 0 and 1 switch the divider off |
| lead_code | input | 7 | Programmed lead interval in clocks |
| post_code | input | 8 | Programmed trailing interval in units of 32 clocks |
| xfer_len | input | 4 | Bits per transfer, 0 meaning 16 |
| cpol | input | 1 | Idle level of sck |
| cpha | input | 1 | Edge assignment of the shift and sample strobes |
| sck | output | 1 | Serial clock |
| cs_act | output | 1 | Chip-select enable |
| shift_stb | output | 1 | One-cycle pulse: present the next data bit |
| sample_stb | output | 1 | One-cycle pulse: capture the incoming data bit |
| busy | output | 1 | Transfer or trailing interval in progress |
| done | output | 1 | One-cycle pulse when the trailing interval ends |

## Verification
A wrong interval counter or phase register shows up at the ports at once as a shifted sck transition, a stray or missing strobe, or a select that drops early or late. The reference model predicts every output of every cycle, so the first cycle in which the design departs from it is reported. A departure in the edge count shows up one half period after the last expected edge. A departure in the trailing interval shows up in the cycle in which busy and done should have changed. Captured-field errors are exposed by changing the inputs in the middle of a transfer, so the change appears within one half period.

// File: rtl/spi_tim_pkg.sv
package spi_tim_pkg;

    localparam int BAUD_W   = 8;
    localparam int LEAD_W   = 7;
    localparam int POST_W   = 8;
    localparam int LEN_W    = 4;
    localparam int POST_SH  = 5;
    localparam int STD_POST = 17;

    localparam int CNT_W     = POST_W + 1 + POST_SH;
    localparam int EDGE_W    = LEN_W + 2;
    localparam int LEAD_ZERO = 1 << LEAD_W;

    typedef enum logic [1:0] {
        ST_IDLE,
        ST_LEAD,
        ST_XFER,
        ST_POST
    } tim_state_e;

    typedef struct packed {
        logic [CNT_W-1:0]  half;
        logic [CNT_W-1:0]  post;
        logic [EDGE_W-1:0] edges;
        logic              cpol;
        logic              cpha;
    } tim_cfg_t;

    function automatic logic [CNT_W-1:0] lead_clks(
        input logic              sel,
        input logic [LEAD_W-1:0] code,
        input logic [BAUD_W-1:0] baud
    );
        if (!sel)
            return CNT_W'(baud);
        if (code == '0)
            return CNT_W'(LEAD_ZERO);
        if (code == LEAD_W'(1))
            return CNT_W'(2);
        return CNT_W'(code);
    endfunction

    function automatic logic [CNT_W-1:0] post_clks(
        input logic              sel,
        input logic [POST_W-1:0] code,
        input int                std_clks
    );
        logic [POST_W:0] mult;
        if (!sel)
            return CNT_W'(std_clks);
        mult = (code == '0) ? {1'b1, {POST_W{1'b0}}} : {1'b0, code};
        return CNT_W'(mult) << POST_SH;
    endfunction

    function automatic logic [EDGE_W-1:0] edge_total(input logic [LEN_W-1:0] len);
        logic [LEN_W:0] bits;
        bits = (len == '0) ? {1'b1, {LEN_W{1'b0}}} : {1'b0, len};
        return {bits, 1'b0};
    endfunction

    // returns {shift, sample} for edge number idx of total
    function automatic logic [1:0] strobe_kind(
        input logic [EDGE_W-1:0] idx,
        input logic [EDGE_W-1:0] total,
        input logic              pha
    );
        logic leading;
        leading = idx[0];
        if (!pha)
            return {(!leading && (idx != total)), leading};
        return {leading, !leading};
    endfunction

endpackage

// File: rtl/spi_tim_cfg.sv
module spi_tim_cfg
    import spi_tim_pkg::*;
#(
    parameter int STD_POST_CLKS = STD_POST
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              load,
    input  logic              lead_sel,
    input  logic              post_sel,
    input  logic [BAUD_W-1:0] baud_code,
    input  logic [LEAD_W-1:0] lead_code,
    input  logic [POST_W-1:0] post_code,
    input  logic [LEN_W-1:0]  xfer_len,
    input  logic              cpol,
    input  logic              cpha,
    output logic [CNT_W-1:0]  lead_now,
    output logic              baud_ok,
    output tim_cfg_t          cfg_q
);

    tim_cfg_t cfg_now;

    always_comb begin
        cfg_now.half  = CNT_W'(baud_code);
        cfg_now.post  = post_clks(post_sel, post_code, STD_POST_CLKS);
        cfg_now.edges = edge_total(xfer_len);
        cfg_now.cpol  = cpol;
        cfg_now.cpha  = cpha;
        lead_now      = lead_clks(lead_sel, lead_code, baud_code);
        baud_ok       = (baud_code >= BAUD_W'(2));
    end

    always_ff @(posedge clk) begin
        if (rst)
            cfg_q <= '0;
        else if (load)
            cfg_q <= cfg_now;
    end

endmodule

// File: rtl/spi_tim_seq.sv
module spi_tim_seq
    import spi_tim_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  logic              start,
    input  logic              baud_ok,
    input  logic [CNT_W-1:0]  lead_now,
    input  logic [CNT_W-1:0]  half_q,
    input  logic [CNT_W-1:0]  post_q,
    input  logic [EDGE_W-1:0] edges_q,
    output logic              accept,
    output logic              edge_fire,
    output logic [EDGE_W-1:0] edge_idx,
    output logic              cs_act,
    output logic              busy,
    output logic              done
);

    tim_state_e        state;
    logic [CNT_W-1:0]  cnt;
    logic [EDGE_W-1:0] ecnt;
    logic              cnt_zero;

    always_comb begin
        cnt_zero  = (cnt == '0);
        accept    = start && (state == ST_IDLE) && baud_ok;
        edge_fire = cnt_zero && ((state == ST_LEAD) ||
                    ((state == ST_XFER) && (ecnt != edges_q)));
        edge_idx  = ecnt + 1'b1;
        cs_act    = (state == ST_LEAD) || (state == ST_XFER);
        busy      = (state != ST_IDLE);
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            state <= ST_IDLE;
            cnt   <= '0;
            ecnt  <= '0;
            done  <= 1'b0;
        end else begin
            done <= 1'b0;
            unique case (state)
                ST_IDLE: begin
                    if (accept) begin
                        state <= ST_LEAD;
                        cnt   <= lead_now - 1'b1;
                        ecnt  <= '0;
                    end
                end
                ST_LEAD: begin
                    if (cnt_zero) begin
                        state <= ST_XFER;
                        cnt   <= half_q - 1'b1;
                        ecnt  <= edge_idx;
                    end else begin
                        cnt <= cnt - 1'b1;
                    end
                end
                ST_XFER: begin
                    if (!cnt_zero) begin
                        cnt <= cnt - 1'b1;
                    end else if (ecnt == edges_q) begin
                        state <= ST_POST;
                        cnt   <= post_q - 1'b1;
                    end else begin
                        cnt  <= half_q - 1'b1;
                        ecnt <= edge_idx;
                    end
                end
                ST_POST: begin
                    if (cnt_zero) begin
                        state <= ST_IDLE;
                        done  <= 1'b1;
                    end else begin
                        cnt <= cnt - 1'b1;
                    end
                end
                default: state <= ST_IDLE;
            endcase
        end
    end

endmodule

// File: rtl/spi_tim_sckgen.sv
module spi_tim_sckgen
    import spi_tim_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  logic              busy,
    input  logic              edge_fire,
    input  logic [EDGE_W-1:0] edge_idx,
    input  logic [EDGE_W-1:0] edges_q,
    input  logic              cpol_live,
    input  logic              cpol_q,
    input  logic              cpha_q,
    output logic              sck,
    output logic              shift_stb,
    output logic              sample_stb
);

    logic       phase;
    logic [1:0] kind;

    always_comb begin
        kind = strobe_kind(edge_idx, edges_q, cpha_q);
        sck  = busy ? (phase ^ cpol_q) : cpol_live;
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            phase      <= 1'b0;
            shift_stb  <= 1'b0;
            sample_stb <= 1'b0;
        end else begin
            if (!busy)
                phase <= 1'b0;
            else if (edge_fire)
                phase <= ~phase;
            shift_stb  <= edge_fire && kind[1];
            sample_stb <= edge_fire && kind[0];
        end
    end

endmodule

// File: rtl/spi_sck_timer.sv
module spi_sck_timer
    import spi_tim_pkg::*;
#(
    parameter int STD_POST_CLKS = STD_POST
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              start,
    input  logic              lead_sel,
    input  logic              post_sel,
    input  logic [BAUD_W-1:0] baud_code,
    input  logic [LEAD_W-1:0] lead_code,
    input  logic [POST_W-1:0] post_code,
    input  logic [LEN_W-1:0]  xfer_len,
    input  logic              cpol,
    input  logic              cpha,
    output logic              sck,
    output logic              cs_act,
    output logic              shift_stb,
    output logic              sample_stb,
    output logic              busy,
    output logic              done
);

    tim_cfg_t          cfg_q;
    logic [CNT_W-1:0]  lead_now;
    logic              baud_ok;
    logic              accept;
    logic              edge_fire;
    logic [EDGE_W-1:0] edge_idx;

    spi_tim_cfg #(
        .STD_POST_CLKS (STD_POST_CLKS)
    ) u_cfg (
        .clk       (clk),
        .rst       (rst),
        .load      (accept),
        .lead_sel  (lead_sel),
        .post_sel  (post_sel),
        .baud_code (baud_code),
        .lead_code (lead_code),
        .post_code (post_code),
        .xfer_len  (xfer_len),
        .cpol      (cpol),
        .cpha      (cpha),
        .lead_now  (lead_now),
        .baud_ok   (baud_ok),
        .cfg_q     (cfg_q)
    );

    spi_tim_seq u_seq (
        .clk       (clk),
        .rst       (rst),
        .start     (start),
        .baud_ok   (baud_ok),
        .lead_now  (lead_now),
        .half_q    (cfg_q.half),
        .post_q    (cfg_q.post),
        .edges_q   (cfg_q.edges),
        .accept    (accept),
        .edge_fire (edge_fire),
        .edge_idx  (edge_idx),
        .cs_act    (cs_act),
        .busy      (busy),
        .done      (done)
    );

    spi_tim_sckgen u_sck (
        .clk        (clk),
        .rst        (rst),
        .busy       (busy),
        .edge_fire  (edge_fire),
        .edge_idx   (edge_idx),
        .edges_q    (cfg_q.edges),
        .cpol_live  (cpol),
        .cpol_q     (cfg_q.cpol),
        .cpha_q     (cfg_q.cpha),
        .sck        (sck),
        .shift_stb  (shift_stb),
        .sample_stb (sample_stb)
    );

endmodule

module spi_sck_timer_chk
    import spi_tim_pkg::*;
(
    input logic              clk,
    input logic              rst,
    input logic              start,
    input logic [BAUD_W-1:0] baud_code,
    input logic              cpol,
    input logic              sck,
    input logic              cs_act,
    input logic              shift_stb,
    input logic              sample_stb,
    input logic              busy,
    input logic              done
);

    a_r1_off_divider_ignores_start: assert property (@(posedge clk) disable iff (rst)
        (start && !busy && (baud_code < BAUD_W'(2))) |=> !busy);

    a_r6_idle_level: assert property (@(posedge clk) disable iff (rst)
        !busy |-> (sck == cpol));

    a_r6_one_strobe: assert property (@(posedge clk) disable iff (rst)
        $onehot0({shift_stb, sample_stb}));

    a_r6_strobe_with_edge: assert property (@(posedge clk) disable iff (rst)
        (shift_stb || sample_stb) |-> (busy && !$stable(sck)));

    a_r2_edge_has_strobe_or_rest: assert property (@(posedge clk) disable iff (rst)
        (busy && $past(busy) && !$stable(sck)) |-> (shift_stb || sample_stb || cs_act));

    a_r8_accept_raises_busy: assert property (@(posedge clk) disable iff (rst)
        (start && !busy && (baud_code >= BAUD_W'(2))) |=> (busy && cs_act));

    a_r8_done_single: assert property (@(posedge clk) disable iff (rst)
        done |=> !done);

    a_r8_done_when_idle: assert property (@(posedge clk) disable iff (rst)
        done |-> !busy);

    a_r8_busy_fall_gives_done: assert property (@(posedge clk) disable iff (rst)
        $fell(busy) |-> done);

    a_r9_select_within_busy: assert property (@(posedge clk) disable iff (rst)
        cs_act |-> busy);

endmodule

bind spi_sck_timer spi_sck_timer_chk u_chk (
    .clk        (clk),
    .rst        (rst),
    .start      (start),
    .baud_code  (baud_code),
    .cpol       (cpol),
    .sck        (sck),
    .cs_act     (cs_act),
    .shift_stb  (shift_stb),
    .sample_stb (sample_stb),
    .busy       (busy),
    .done       (done)
);

// File: tb/tb_spi_sck_timer.sv
module tb_spi_sck_timer;

    logic       clk = 1'b0;
    logic       rst = 1'b1;
    logic       start = 1'b0;
    logic       lead_sel = 1'b0;
    logic       post_sel = 1'b0;
    logic [7:0] baud_code = 8'd4;
    logic [6:0] lead_code = 7'd0;
    logic [7:0] post_code = 8'd0;
    logic [3:0] xfer_len = 4'd8;
    logic       cpol = 1'b0;
    logic       cpha = 1'b0;
    logic       sck, cs_act, shift_stb, sample_stb, busy, done;

    int    n_chk = 0;
    int    n_fail = 0;
    bit    armed = 1'b0;
    string idle_tag = "R11";
    string lead_tag = "R3";
    string xfer_tag = "R2";

    // expected {cs_act, sck, shift_stb, sample_stb, busy, done} per cycle
    logic [5:0] exp_q[$];
    string      tag_q[$];

    always #2 clk = ~clk;

    spi_sck_timer dut (
        .clk        (clk),
        .rst        (rst),
        .start      (start),
        .lead_sel   (lead_sel),
        .post_sel   (post_sel),
        .baud_code  (baud_code),
        .lead_code  (lead_code),
        .post_code  (post_code),
        .xfer_len   (xfer_len),
        .cpol       (cpol),
        .cpha       (cpha),
        .sck        (sck),
        .cs_act     (cs_act),
        .shift_stb  (shift_stb),
        .sample_stb (sample_stb),
        .busy       (busy),
        .done       (done)
    );

    task automatic chk(input bit ok, input string tag, input string what,
                       input int act, input int expv);
        n_chk++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s %s at %0t: actual %0d expected %0d", tag, what, $time, act, expv);
        end
    endtask

    function automatic void push_xfer(input int b, input bit ls, input int lc,
                                      input bit ps, input int pc, input int ln,
                                      input bit pol, input bit pha,
                                      input string tl, input string tx);
        int lead_n = ls ? ((lc == 0) ? 128 : ((lc == 1) ? 2 : lc)) : b;
        int bits   = (ln == 0) ? 16 : ln;
        int post_n = ps ? 32 * ((pc == 0) ? 256 : pc) : 17;
        for (int k = 0; k < lead_n; k++) begin
            exp_q.push_back({1'b1, pol, 2'b00, 1'b1, 1'b0});
            tag_q.push_back(tl);
        end
        for (int i = 1; i <= 2 * bits; i++) begin
            for (int j = 0; j < b; j++) begin
                logic lvl, sh, sa;
                lvl = pol ^ i[0];
                sh = 1'b0;
                sa = 1'b0;
                if (j == 0) begin
                    if (!pha) begin
                        sa = i[0];
                        sh = !i[0] && (i != 2 * bits);
                    end else begin
                        sh = i[0];
                        sa = !i[0];
                    end
                end
                exp_q.push_back({1'b1, lvl, sh, sa, 1'b1, 1'b0});
                tag_q.push_back(tx);
            end
        end
        for (int k = 0; k < post_n; k++) begin
            exp_q.push_back({1'b0, pol, 2'b00, 1'b1, 1'b0});
            tag_q.push_back("R7");
        end
        exp_q.push_back({1'b0, pol, 2'b00, 1'b0, 1'b1});
        tag_q.push_back("R8");
    endfunction

    // reference model: compare on every clock, then predict acceptance
    always @(negedge clk) begin
        logic [5:0] e;
        string      t;
        if (armed) begin
            if (rst) begin
                exp_q.delete();
                tag_q.delete();
            end
            if (!rst && exp_q.size() > 0) begin
                e = exp_q.pop_front();
                t = tag_q.pop_front();
            end else begin
                e = {1'b0, cpol, 2'b00, 1'b0, 1'b0};
                t = rst ? "R11" : idle_tag;
            end
            chk(cs_act == e[5], "R9", "cs_act", cs_act, e[5]);
            chk(sck == e[4], t, "sck", sck, e[4]);
            chk(shift_stb == e[3], "R6", "shift_stb", shift_stb, e[3]);
            chk(sample_stb == e[2], "R6", "sample_stb", sample_stb, e[2]);
            chk(busy == e[1], t, "busy", busy, e[1]);
            chk(done == e[0], "R8", "done", done, e[0]);
            if (!rst && start && !e[1] && (baud_code >= 8'd2))
                push_xfer(baud_code, lead_sel, lead_code, post_sel, post_code,
                          xfer_len, cpol, cpha, lead_tag, xfer_tag);
        end
    end

    task automatic go(input int b, input bit ls, input int lc, input bit ps,
                      input int pc, input int ln, input bit pol, input bit pha,
                      input string tl, input string tx);
        @(posedge clk);
        #1;
        baud_code = 8'(b);
        lead_sel  = ls;
        lead_code = 7'(lc);
        post_sel  = ps;
        post_code = 8'(pc);
        xfer_len  = 4'(ln);
        cpol      = pol;
        cpha      = pha;
        lead_tag  = tl;
        xfer_tag  = tx;
        start     = 1'b1;
        @(posedge clk);
        #1;
        start = 1'b0;
    endtask

    task automatic drain();
        while (exp_q.size() > 0)
            @(posedge clk);
        repeat (4) @(posedge clk);
    endtask

    initial begin
        @(posedge clk);
        armed = 1'b1;
        repeat (3) @(posedge clk);
        #1;
        rst = 1'b0;
        repeat (3) @(posedge clk);

        // R1: divider off for codes 0 and 1
        idle_tag = "R1";
        go(0, 0, 0, 0, 0, 2, 0, 0, "R1", "R1");
        repeat (6) @(posedge clk);
        go(1, 1, 9, 0, 0, 2, 1, 0, "R1", "R1");
        repeat (6) @(posedge clk);

        // R3 / R2: standard lead, fastest divider
        idle_tag = "R8";
        go(2, 0, 0, 0, 0, 3, 0, 0, "R3", "R2");
        drain();

        // R4: lead code 0 -> 128, cpol 1, cpha 1, post 32 clocks
        go(4, 1, 0, 1, 1, 1, 1, 1, "R4", "R6");
        drain();

        // R4: lead code 1 behaves as 2
        go(3, 1, 1, 0, 0, 2, 0, 0, "R4", "R2");
        drain();

        // R5 / R7: length 0 means 16 bits, post code 0 means 256 x 32
        go(2, 1, 5, 1, 0, 0, 0, 1, "R4", "R5");
        drain();

        // R2: slowest divider
        go(255, 0, 0, 0, 0, 1, 1, 0, "R3", "R2");
        drain();

        // R10 / R8: fields change and start repeats during a transfer
        go(5, 0, 0, 0, 0, 4, 0, 0, "R10", "R10");
        repeat (10) @(posedge clk);
        #1;
        baud_code = 8'd2;
        lead_sel  = 1'b1;
        lead_code = 7'd40;
        xfer_len  = 4'd1;
        cpha      = 1'b1;
        post_sel  = 1'b1;
        post_code = 8'd3;
        start     = 1'b1;
        @(posedge clk);
        #1;
        start = 1'b0;
        drain();

        // R8: start held through a transfer is accepted again in the done cycle
        @(posedge clk);
        #1;
        baud_code = 8'd2;
        lead_sel  = 1'b0;
        post_sel  = 1'b0;
        xfer_len  = 4'd1;
        cpha      = 1'b0;
        lead_tag  = "R8";
        xfer_tag  = "R8";
        start     = 1'b1;
        @(negedge clk iff done);
        @(posedge clk);
        #1;
        start = 1'b0;
        drain();

        $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
        $finish;
    end

    initial begin
        #(4 * 200000);
        n_chk++;
        n_fail++;
        $display("FAIL watchdog: actual running expected finished");
        $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
        $finish;
    end

endmodule